// File: doc/BRIEF.md
# 32-bit Shifter with Carry-Out and Result Flags

This block is the shift stage of a compact 16-bit-instruction processor datapath. It is purely combinational: a 32-bit operand, a 2-bit shift operation, an amount and the incoming carry flag go in. The shifted value, the updated carry and the negative and zero flags come out in the same cycle. The overflow flag is not touched by any shift, so it has no port here.

The amount comes from one of two sources. The first is a 5-bit field taken from the instruction. The second is the low byte of a register, which the surrounding datapath delivers on an 8-bit port. A select input picks the source. The two sources treat out-of-range amounts differently. An immediate zero means "no shift" for left shifts and "shift by 32" for right shifts. A register byte can be anywhere from 0 to 255, and it has its own rules for exactly 32, above 32, and whole multiples of 32 when rotating. The block applies all of these rules itself, so instruction decode only passes the raw fields through.

Top module: `shu_shift_unit`

## Requirements
- R1: With `use_reg_amt_i` = 0, operation LSL (`op_i` = 00) and an immediate amount of 0, the result equals the operand and `carry_o` equals `carry_i`.
- R2: With `use_reg_amt_i` = 0 and an immediate amount of 0, LSR (`op_i` = 01) returns 0 and ASR (`op_i` = 10) returns 32 copies of operand bit 31. In both cases `carry_o` is operand bit 31.
- R3: With `use_reg_amt_i` = 0 and an immediate amount n from 1 to 31, the result is the operand shifted by n. LSL sets `carry_o` to operand bit 32−n. LSR and ASR set it to bit n−1. ASR fills from the left with bit 31 and LSL/LSR fill with zeros.
- R4: With `use_reg_amt_i` = 1, the 8-bit `reg_amt_i` is the amount. An amount of 0 leaves both the result (equal to the operand) and the carry (equal to `carry_i`) unchanged, for every operation.
- R5: A register amount n from 1 to 31 shifts LSL, LSR and ASR by n, with the same carry bits as R3.
- R6: A register LSL by exactly 32 gives 0 with carry equal to operand bit 0. A register LSR by exactly 32 gives 0 with carry equal to bit 31. Register LSL or LSR by 33 to 255 gives 0 with carry 0.
- R7: A register ASR by 32 to 255 gives 32 copies of operand bit 31, with carry equal to bit 31.
- R8: A register ROR (`op_i` = 11) uses the amount modulo 32. A nonzero remainder r rotates right by r and sets carry to operand bit r−1. A nonzero amount that is a multiple of 32 leaves the value unchanged and sets carry to bit 31.
- R9: With `use_reg_amt_i` = 0, ROR uses the 5-bit immediate directly as its rotate amount. A value of 0 leaves the result and carry unchanged.
- R10: For every operation and amount, `neg_o` equals result bit 31, and `zero_o` is 1 exactly when the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Value to be shifted |
| op_i | input | 2 | Shift operation: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| use_reg_amt_i | input | 1 | 1 selects the register amount, 0 the immediate amount |
| imm_amt_i | input | 5 | Amount field from the instruction |
| reg_amt_i | input | 8 | Low byte of the amount register |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Updated carry flag |
| neg_o | output | 1 | Negative flag of the result |
| zero_o | output | 1 | Zero flag of the result |

## Verification
The bound checker tests the special-amount rules at every moment they apply. These are: the immediate LSL-by-zero pass-through, the register zero-amount hold, register LSR beyond 32 clearing value and carry, register ASR of 32 or more filling with the sign, rotation by a whole multiple of 32, and the flag relation to the result. The in-range shifts are checked only by the bench's scenarios. Those are the carry bit position for each amount, the exact-32 cases of LSL and LSR, immediate right shifts encoded as zero, and rotation by a nonzero remainder. The bench compares all four outputs against its own model while it sweeps amounts 0, 1, 31, 32, 33 and 255 with random operands.

// File: rtl/shu_pkg.sv
package shu_pkg;

  typedef enum logic [1:0] {
    SHOP_LSL = 2'b00,
    SHOP_LSR = 2'b01,
    SHOP_ASR = 2'b10,
    SHOP_ROR = 2'b11
  } shu_op_e;

  // Amount classes after normalising immediate and register forms
  typedef enum logic [1:0] {
    AMT_NONE = 2'd0,  // no shift: value and carry held
    AMT_PART = 2'd1,  // 1 .. width-1 (or nonzero rotate remainder)
    AMT_FULL = 2'd2,  // exactly width (or rotate by whole multiple)
    AMT_OVER = 2'd3   // beyond width
  } shu_amt_cls_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } shu_fill_e;

endpackage

// File: rtl/shu_amount_decode.sv
module shu_amount_decode
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  parameter int SHF_W  = $clog2(DATA_W)
) (
  input  shu_op_e             op_i,
  input  logic                use_reg_i,
  input  logic [SHF_W-1:0]    imm_i,
  input  logic [RAMT_W-1:0]   reg_amt_i,
  output shu_amt_cls_e        cls_o,
  output logic [SHF_W-1:0]    sub_o
);

  localparam logic [RAMT_W-1:0] FULL_AMT = RAMT_W'(DATA_W);

  logic [RAMT_W-1:0] eff_amt;
  logic              imm_zero_right;

  always_comb begin
    imm_zero_right = (imm_i == '0) && ((op_i == SHOP_LSR) || (op_i == SHOP_ASR));
    if (use_reg_i) begin
      eff_amt = reg_amt_i;
    end else if (imm_zero_right) begin
      eff_amt = FULL_AMT;
    end else begin
      eff_amt = RAMT_W'(imm_i);
    end
  end

  always_comb begin
    sub_o = eff_amt[SHF_W-1:0];
    if (eff_amt == '0) begin
      cls_o = AMT_NONE;
    end else if (op_i == SHOP_ROR) begin
      cls_o = (eff_amt[SHF_W-1:0] != '0) ? AMT_PART : AMT_FULL;
    end else if (eff_amt < FULL_AMT) begin
      cls_o = AMT_PART;
    end else if (eff_amt == FULL_AMT) begin
      cls_o = AMT_FULL;
    end else begin
      cls_o = AMT_OVER;
    end
  end

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHF_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SHF_W-1:0]  amt_i,
  input  logic              rev_i,   // left shift via bit reversal
  input  shu_fill_e         fill_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] stg [SHF_W+1];
  logic [DATA_W-1:0] din_rev;
  logic [DATA_W-1:0] out_rev;
  logic              fill_bit;
  logic              wrap;

  assign fill_bit = (fill_i == FILL_SIGN) & data_i[DATA_W-1];
  assign wrap     = (fill_i == FILL_WRAP);

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
    assign din_rev[gi] = data_i[DATA_W-1-gi];
    assign out_rev[gi] = stg[SHF_W][DATA_W-1-gi];
  end

  assign stg[0] = rev_i ? din_rev : data_i;

  // One right-shift stage per amount bit
  for (genvar gk = 0; gk < SHF_W; gk++) begin : g_stage
    localparam int STEP = 1 << gk;
    logic [DATA_W-1:0] moved;

    always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
        if (i + STEP < DATA_W) begin
          moved[i] = stg[gk][SHF_W'((i + STEP) % DATA_W)];
        end else begin
          moved[i] = wrap ? stg[gk][SHF_W'((i + STEP) % DATA_W)] : fill_bit;
        end
      end
    end

    assign stg[gk+1] = amt_i[gk] ? moved : stg[gk];
  end

  assign data_o = rev_i ? out_rev : stg[SHF_W];

endmodule

// File: rtl/shu_flag_sel.sv
module shu_flag_sel
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHF_W  = $clog2(DATA_W)
) (
  input  shu_op_e           op_i,
  input  shu_amt_cls_e      cls_i,
  input  logic [SHF_W-1:0]  sub_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [DATA_W-1:0] shifted_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o
);

  logic [SHF_W-1:0]  lsl_idx;
  logic [SHF_W-1:0]  rsh_idx;
  logic              sign;
  logic [DATA_W-1:0] res;
  logic              cy;

  always_comb begin
    lsl_idx = SHF_W'(0) - sub_i;        // width - n
    rsh_idx = sub_i - SHF_W'(1);        // n - 1
    sign    = opnd_i[DATA_W-1];
    res     = opnd_i;
    cy      = carry_i;
    unique case (cls_i)
      AMT_NONE: begin
        res = opnd_i;
        cy  = carry_i;
      end
      AMT_PART: begin
        res = shifted_i;
        unique case (op_i)
          SHOP_LSL: cy = opnd_i[lsl_idx];
          SHOP_ROR: cy = shifted_i[DATA_W-1];
          default:  cy = opnd_i[rsh_idx];
        endcase
      end
      AMT_FULL: begin
        unique case (op_i)
          SHOP_LSL: begin res = '0;               cy = opnd_i[0]; end
          SHOP_LSR: begin res = '0;               cy = sign;      end
          SHOP_ASR: begin res = {DATA_W{sign}};   cy = sign;      end
          default:  begin res = opnd_i;           cy = sign;      end
        endcase
      end
      default: begin
        if (op_i == SHOP_ASR) begin
          res = {DATA_W{sign}};
          cy  = sign;
        end else begin
          res = '0;
          cy  = 1'b0;
        end
      end
    endcase
  end

  assign result_o = res;
  assign carry_o  = cy;
  assign neg_o    = res[DATA_W-1];
  assign zero_o   = ~|res;

endmodule

// File: rtl/shu_shift_unit.sv
module shu_shift_unit
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  localparam int SHF_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        op_i,
  input  logic              use_reg_amt_i,
  input  logic [SHF_W-1:0]  imm_amt_i,
  input  logic [RAMT_W-1:0] reg_amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              neg_o,
  output logic              zero_o
);

  shu_op_e           op;
  shu_amt_cls_e      cls;
  logic [SHF_W-1:0]  sub_amt;
  shu_fill_e         fill;
  logic              rev;
  logic [DATA_W-1:0] shifted;

  assign op  = shu_op_e'(op_i);
  assign rev = (op == SHOP_LSL);

  always_comb begin
    unique case (op)
      SHOP_ASR: fill = FILL_SIGN;
      SHOP_ROR: fill = FILL_WRAP;
      default:  fill = FILL_ZERO;
    endcase
  end

  shu_amount_decode #(
    .DATA_W (DATA_W),
    .RAMT_W (RAMT_W),
    .SHF_W  (SHF_W)
  ) u_amt (
    .op_i      (op),
    .use_reg_i (use_reg_amt_i),
    .imm_i     (imm_amt_i),
    .reg_amt_i (reg_amt_i),
    .cls_o     (cls),
    .sub_o     (sub_amt)
  );

  shu_barrel #(
    .DATA_W (DATA_W),
    .SHF_W  (SHF_W)
  ) u_bar (
    .data_i (opnd_i),
    .amt_i  (sub_amt),
    .rev_i  (rev),
    .fill_i (fill),
    .data_o (shifted)
  );

  shu_flag_sel #(
    .DATA_W (DATA_W),
    .SHF_W  (SHF_W)
  ) u_flg (
    .op_i      (op),
    .cls_i     (cls),
    .sub_i     (sub_amt),
    .opnd_i    (opnd_i),
    .shifted_i (shifted),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .neg_o     (neg_o),
    .zero_o    (zero_o)
  );

endmodule

// File: rtl/shu_shift_unit_chk.sv
module shu_shift_unit_chk #(
  parameter int DATA_W = 32,
  parameter int RAMT_W = 8,
  localparam int SHF_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] opnd_i,
  input logic [1:0]        op_i,
  input logic              use_reg_amt_i,
  input logic [SHF_W-1:0]  imm_amt_i,
  input logic [RAMT_W-1:0] reg_amt_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              neg_o,
  input logic              zero_o
);

  localparam logic [RAMT_W-1:0] FULL_AMT = RAMT_W'(DATA_W);

  always_comb begin
    // R1: immediate LSL by zero is a pass-through
    if (!use_reg_amt_i && op_i == 2'b00 && imm_amt_i == '0) begin
      p_imm_lsl_zero_r1: assert (result_o == opnd_i && carry_o == carry_i);
    end
    // R4: zero register amount holds value and carry
    if (use_reg_amt_i && reg_amt_i == '0) begin
      p_reg_zero_hold_r4: assert (result_o == opnd_i && carry_o == carry_i);
    end
    // R6: register LSR beyond width clears value and carry
    if (use_reg_amt_i && op_i == 2'b01 && reg_amt_i > FULL_AMT) begin
      p_lsr_beyond_r6: assert (result_o == '0 && !carry_o);
    end
    // R7: register ASR of width or more fills with sign
    if (use_reg_amt_i && op_i == 2'b10 && reg_amt_i >= FULL_AMT) begin
      p_asr_fill_r7: assert (result_o == {DATA_W{opnd_i[DATA_W-1]}}
                             && carry_o == opnd_i[DATA_W-1]);
    end
    // R8: rotate by a whole nonzero multiple of width
    if (use_reg_amt_i && op_i == 2'b11 && reg_amt_i != '0
        && reg_amt_i[SHF_W-1:0] == '0) begin
      p_ror_whole_r8: assert (result_o == opnd_i && carry_o == opnd_i[DATA_W-1]);
    end
    // R10: flags follow the result
    p_flags_r10: assert (neg_o == result_o[DATA_W-1]
                         && zero_o == (result_o == '0));
  end

endmodule

bind shu_shift_unit shu_shift_unit_chk #(
  .DATA_W (DATA_W),
  .RAMT_W (RAMT_W)
) u_chk (.*);

// File: tb/shu_shift_unit_tb.sv
module shu_shift_unit_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [1:0]  op;
  logic        use_reg;
  logic [4:0]  imm_amt;
  logic [7:0]  reg_amt;
  logic        cin;
  logic [31:0] result;
  logic        cout;
  logic        neg;
  logic        zero;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  shu_shift_unit u_dut (
    .opnd_i        (opnd),
    .op_i          (op),
    .use_reg_amt_i (use_reg),
    .imm_amt_i     (imm_amt),
    .reg_amt_i     (reg_amt),
    .carry_i       (cin),
    .result_o      (result),
    .carry_o       (cout),
    .neg_o         (neg),
    .zero_o        (zero)
  );

  // Behavioural model of the shift rules
  task automatic model(input logic [1:0] m_op, input bit m_reg, input logic [4:0] m_imm,
                       input logic [7:0] m_ramt, input logic [31:0] a, input bit c_in,
                       output logic [31:0] r, output bit c);
    int amt;
    logic [63:0] x;
    amt = m_reg ? int'(m_ramt) : int'(m_imm);
    if (!m_reg && m_imm == 0 && (m_op == 2'd1 || m_op == 2'd2)) amt = 32;
    r = a;
    c = c_in;
    if (amt > 0) begin
      case (m_op)
        2'd0: begin
          x = {32'h0, a} << amt;
          r = x[31:0];
          c = x[32];
        end
        2'd1: begin
          x = {a, 32'h0} >> amt;
          r = x[63:32];
          c = x[31];
        end
        2'd2: begin
          x = $signed({a, 32'h0}) >>> ((amt > 32) ? 32 : amt);
          r = x[63:32];
          c = x[31];
        end
        default: begin
          int rr;
          rr = amt % 32;
          if (rr == 0) begin
            c = a[31];
          end else begin
            r = (a >> rr) | (a << (32 - rr));
            c = a[rr-1];
          end
        end
      endcase
    end
  endtask

  function automatic string tag_of(input logic [1:0] t_op, input bit t_reg,
                                   input logic [4:0] t_imm, input logic [7:0] t_ramt);
    if (!t_reg) begin
      if (t_op == 2'd3) return "R9";
      if (t_imm == 0) return (t_op == 2'd0) ? "R1" : "R2";
      return "R3";
    end
    if (t_ramt == 0) return "R4";
    if (t_op == 2'd3) return "R8";
    if (t_ramt < 32) return "R5";
    if (t_op == 2'd2) return "R7";
    return "R6";
  endfunction

  task automatic compare(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (op=%0d reg=%0d imm=%0d ramt=%0d a=%h)",
               tag, what, act, exp, op, use_reg, imm_amt, reg_amt, opnd);
    end
  endtask

  task automatic apply(input logic [1:0] a_op, input bit a_reg, input logic [4:0] a_imm,
                       input logic [7:0] a_ramt, input logic [31:0] a_val, input bit a_cin);
    logic [31:0] er;
    bit          ec;
    string       tg;
    @(negedge clk);
    op      = a_op;
    use_reg = a_reg;
    imm_amt = a_imm;
    reg_amt = a_ramt;
    opnd    = a_val;
    cin     = a_cin;
    @(posedge clk);
    model(a_op, a_reg, a_imm, a_ramt, a_val, a_cin, er, ec);
    tg = tag_of(a_op, a_reg, a_imm, a_ramt);
    compare(tg, "result", result, er);
    compare(tg, "carry", {31'h0, cout}, {31'h0, ec});
    compare("R10", "neg", {31'h0, neg}, {31'h0, er[31]});
    compare("R10", "zero", {31'h0, zero}, {31'h0, (er == 32'h0)});
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int amts [6] = '{0, 1, 31, 32, 33, 255};
    int imms [5] = '{0, 1, 7, 16, 31};
    opnd = '0; op = '0; use_reg = 1'b0; imm_amt = '0; reg_amt = '0; cin = 1'b0;
    repeat (3) @(posedge clk);

    // Idle state: all-zero inputs (R1 pass-through, R10 zero flag)
    apply(2'd0, 1'b0, 5'd0, 8'd0, 32'h0, 1'b0);
    // Directed corners
    apply(2'd0, 1'b0, 5'd0, 8'd0, 32'h8000_0001, 1'b1);  // R1 carry kept
    apply(2'd1, 1'b0, 5'd0, 8'd0, 32'h8000_0000, 1'b0);  // R2 LSR #0
    apply(2'd2, 1'b0, 5'd0, 8'd0, 32'h8765_4321, 1'b0);  // R2 ASR #0
    apply(2'd2, 1'b0, 5'd0, 8'd0, 32'h7FFF_FFFF, 1'b1);  // R2 ASR #0 positive
    apply(2'd0, 1'b1, 5'd0, 8'd32, 32'h0000_0001, 1'b0); // R6 LSL 32 carry bit0
    apply(2'd1, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0); // R6 LSR 32 carry bit31
    apply(2'd0, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1); // R6 LSL >32 carry clear
    apply(2'd3, 1'b1, 5'd0, 8'd64, 32'h8000_0000, 1'b0); // R8 multiple of 32
    apply(2'd3, 1'b1, 5'd0, 8'd96, 32'h1234_5678, 1'b1); // R8 multiple of 32
    apply(2'd3, 1'b1, 5'd0, 8'd36, 32'h0000_0008, 1'b0); // R8 remainder 4
    apply(2'd3, 1'b0, 5'd0, 8'd0, 32'hCAFE_F00D, 1'b1);  // R9 imm ROR 0
    apply(2'd3, 1'b0, 5'd4, 8'd0, 32'h0000_000F, 1'b0);  // R9 imm ROR 4
    apply(2'd0, 1'b1, 5'd0, 8'd1, 32'h8000_0000, 1'b0);  // R5 result zero
    for (int o = 0; o < 4; o++) begin
      apply(2'(o), 1'b1, 5'd0, 8'd0, 32'hDEAD_BEEF, 1'b1); // R4 zero hold
      apply(2'(o), 1'b1, 5'd0, 8'd0, 32'h0000_0000, 1'b0); // R4 zero hold
    end

    // Register-amount sweep (R4, R5, R6, R7, R8)
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 6; k++) begin
        for (int j = 0; j < 4; j++) begin
          apply(2'(o), 1'b1, 5'($urandom), 8'(amts[k]), $urandom, 1'($urandom));
        end
      end
    end
    // Immediate sweep (R1, R2, R3, R9)
    for (int o = 0; o < 4; o++) begin
      for (int k = 0; k < 5; k++) begin
        for (int j = 0; j < 3; j++) begin
          apply(2'(o), 1'b0, 5'(imms[k]), 8'($urandom), $urandom, 1'($urandom));
        end
      end
    end
    // Random mix over all amounts
    for (int j = 0; j < 200; j++) begin
      apply(2'($urandom), 1'($urandom), 5'($urandom), 8'($urandom), $urandom, 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule